// File: doc/BRIEF.md
# Modem Control and Status with Loopback

This block holds the modem control settings of a 16550-style serial port and reports the state of its four modem status lines. Software writes a control byte that drives the data-terminal-ready and request-to-send outputs, two general-purpose output bits and a loopback enable. A status byte reports the current level of clear-to-send, data-set-ready, ring indicator and carrier detect, together with a sticky change flag for each line.

The external status inputs are asynchronous. Each passes through a two-flop synchronizer before any edge is detected. In loopback the four control bits feed the status lines internally, the external ready and request outputs go low, and activity on the external inputs is not recorded. The ring change flag records only a falling ring level. Clear-to-send, data-set-ready and carrier detect record a change in either direction.

A status read strobe clears every change flag. The interrupt request output stays high while any change flag is set.

Top module: `modem_ctl_top`

## Requirements
- R1: After reset the control byte reads 0x00, the status change flags (status bits 3:0) are 0, and dtr_o, rts_o and irq_o are 0.
- R2: A control write stores wdata bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OP1, bit 3 OP2, bit 4 loopback), visible one edge later. Control read bits 7:5 are always 0.
- R3: Outside loopback, dtr_o and rts_o follow control bits 0 and 1. While control bit 4 is set, both are 0.
- R4: Outside loopback, status bit 4 is the synchronized cts_i, bit 5 dsr_i, bit 6 ri_i and bit 7 cd_i. Each reflects its input two clock edges after the input is sampled.
- R5: In loopback, status bit 4 equals control bit 1 (RTS), bit 5 equals bit 0 (DTR), bit 6 equals bit 2 (OP1) and bit 7 equals bit 3 (OP2).
- R6: Outside loopback, any change of synchronized CTS, DSR or CD sets change flag bit 0, 1 or 3 respectively. The flag is set one edge after the new level appears in the status byte.
- R7: The ring change flag (status bit 2) is set only when the ring level goes from 1 to 0, in normal mode and in loopback alike.
- R8: In loopback, changes on the external inputs set no change flag. A control write with bit 4 set raises the flags of every looped line whose level it changes, following R6 and R7, on the same edge.
- R9: A status read strobe clears all four change flags on the next edge. A flag set on that same edge stays set.
- R10: irq_o is 1 exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| stat_rd_i | input | 1 | Status register read strobe, clears change flags |
| cts_i | input | 1 | External clear-to-send, asynchronous |
| dsr_i | input | 1 | External data-set-ready, asynchronous |
| ri_i | input | 1 | External ring indicator, asynchronous |
| cd_i | input | 1 | External carrier detect, asynchronous |
| ctl_rdata_o | output | 8 | Control register read value |
| stat_rdata_o | output | 8 | Status register read value: levels 7:4, change flags 3:0 |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
Latency differs by path. After an external input changes, its status level is due two edges later and its change flag three edges later. A control write, and any change flag it raises in loopback, takes effect on the first edge. A read strobe clears the flags on the first edge.

The bench drives each stimulus just after a falling edge. It waits that exact number of rising edges before it samples, so each check lands in the first cycle the result is due. The sweeps cover every pair of old and new line levels in both modes, and every expected flag is worked out in the bench from that pair.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int NLINES = 4;
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_CD  = 3;

  typedef struct packed {
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } ctl_t;

  // status line levels seen in loopback
  function automatic logic [NLINES-1:0] looped_lines(ctl_t c);
    logic [NLINES-1:0] l;
    l[L_CTS] = c.rts;
    l[L_DSR] = c.dtr;
    l[L_RI]  = c.op1;
    l[L_CD]  = c.op2;
    return l;
  endfunction

  // change mask; ring counts only its trailing edge
  function automatic logic [NLINES-1:0] change_mask(logic [NLINES-1:0] prev,
                                                    logic [NLINES-1:0] cur);
    logic [NLINES-1:0] m;
    m = prev ^ cur;
    m[L_RI] = prev[L_RI] & ~cur[L_RI];
    return m;
  endfunction
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
  import modem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output ctl_t              ctl_o,
  output logic [NLINES-1:0] loop_set_o
);
  localparam int CW = $bits(ctl_t);

  ctl_t ctl_q;
  ctl_t ctl_d;

  assign ctl_d = ctl_t'(wdata_i[CW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= ctl_d;
  end

  // looped line changes caused by a write that leaves loopback on
  always_comb begin
    loop_set_o = '0;
    if (wr_i && ctl_d.loop)
      loop_set_o = change_mask(looped_lines(ctl_q), looped_lines(ctl_d));
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i) | set_i[i]; // set wins
    end
    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/modem_ctl_top.sv
module modem_ctl_top
  import modem_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [DW-1:0] ctl_wdata_i,
  input  logic          stat_rd_i,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          cd_i,
  output logic [DW-1:0] ctl_rdata_o,
  output logic [DW-1:0] stat_rdata_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          irq_o
);
  localparam int CW = $bits(ctl_t);

  ctl_t              ctl;
  logic [NLINES-1:0] loop_set;
  logic [NLINES-1:0] ext_raw, ext_sync, ext_prev_q, ext_set;
  logic [NLINES-1:0] lines, flags;

  assign ext_raw[L_CTS] = cts_i;
  assign ext_raw[L_DSR] = dsr_i;
  assign ext_raw[L_RI]  = ri_i;
  assign ext_raw[L_CD]  = cd_i;

  modem_ctl_reg #(.DW(DW)) u_ctl (
    .clk_i, .rst_ni,
    .wr_i       (ctl_wr_i),
    .wdata_i    (ctl_wdata_i),
    .ctl_o      (ctl),
    .loop_set_o (loop_set)
  );

  modem_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i (ext_raw),
    .q_o (ext_sync)
  );

  // prev tracks in every mode, so leaving loopback raises nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= '0;
    else         ext_prev_q <= ext_sync;
  end

  assign ext_set = ctl.loop ? '0 : change_mask(ext_prev_q, ext_sync);
  assign lines   = ctl.loop ? looped_lines(ctl) : ext_sync;

  modem_delta #(.N(NLINES)) u_delta (
    .clk_i, .rst_ni,
    .set_i  (ext_set | loop_set),
    .clr_i  (stat_rd_i),
    .flag_o (flags)
  );

  assign ctl_rdata_o  = {{(DW-CW){1'b0}}, ctl};
  assign stat_rdata_o = {{(DW-2*NLINES){1'b0}}, lines, flags};
  assign dtr_o        = ctl.dtr & ~ctl.loop;
  assign rts_o        = ctl.rts & ~ctl.loop;
  assign irq_o        = |flags;
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_wr_i,
  input logic [7:0] ctl_wdata_i,
  input logic       stat_rd_i,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       ri_i,
  input logic       cd_i,
  input logic [7:0] ctl_rdata_o,
  input logic [7:0] stat_rdata_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       irq_o
);
  // R2
  ctl_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[7:5] == 3'b000);

  // R3
  loop_outputs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[4] |-> (!dtr_o && !rts_o));

  // R5
  loop_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[4] |-> stat_rdata_o[7:4] ==
      {ctl_rdata_o[3], ctl_rdata_o[2], ctl_rdata_o[0], ctl_rdata_o[1]});

  // R9
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ctl_wr_i && ctl_rdata_o[4]) |=> stat_rdata_o[3:0] == 4'h0);

  // R10
  irq_on_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rdata_o[3:0] != 4'h0) |-> irq_o);
endmodule

bind modem_ctl_top modem_ctl_chk chk_i (.*);

// File: tb/modem_ctl_top_test.sv
`timescale 1ns/1ps
module modem_ctl_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       stat_rd = 1'b0;
  logic       cts = 1'b0, dsr = 1'b0, ri = 1'b0, cd = 1'b0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic       dtr, rts, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  modem_ctl_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .stat_rd_i(stat_rd),
    .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .cd_i(cd),
    .ctl_rdata_o(ctl_rdata), .stat_rdata_o(stat_rdata),
    .dtr_o(dtr), .rts_o(rts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // expected flags: {cd,ri,dsr,cts} nibble order
  function automatic logic [3:0] exp_flags(logic [3:0] o, logic [3:0] n);
    logic [3:0] m;
    m = o ^ n;
    m[2] = o[2] & ~n[2];
    return m;
  endfunction

  function automatic logic [3:0] loop_lines(logic [3:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic rd_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic set_ext(input logic [3:0] v);
    @(negedge clk); {cd, ri, dsr, cts} = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 flags", {4'h0, stat_rdata[3:0]}, 8'h00);
    chk("R1 outs", {5'b0, dtr, rts, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 write/readback with upper bits set
    for (int v = 0; v < 256; v += 37) begin
      wr_ctl(8'(v) & 8'hEF);
      chk("R2 ctl readback", ctl_rdata, 8'(v) & 8'h0F);
      // R3 outputs outside loopback
      chk("R3 dtr/rts", {6'b0, rts, dtr}, {6'b0, 8'(v) & 8'h03});
    end
    wr_ctl(8'hF3);
    chk("R2 upper zero", ctl_rdata, 8'h13);
    chk("R3 loop outputs low", {6'b0, rts, dtr}, 8'h00);
    wr_ctl(8'h03);
    chk("R3 outputs restored", {6'b0, rts, dtr}, 8'h03);
    wr_ctl(8'h00);
    rd_stat();

    // R4 R6 R7 R10 normal-mode sweep of all level pairs
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        set_ext(4'(o));
        repeat (1) @(negedge clk);
        rd_stat();
        chk("R9 cleared", {4'h0, stat_rdata[3:0]}, 8'h00);
        @(negedge clk); {cd, ri, dsr, cts} = 4'(n);
        repeat (2) @(negedge clk);
        chk("R4 level", {4'h0, stat_rdata[7:4]}, {4'h0, 4'(n)});
        @(negedge clk);
        chk("R6 R7 flags", stat_rdata, {4'(n), exp_flags(4'(o), 4'(n))});
        chk("R10 irq", {7'b0, irq}, {7'b0, |exp_flags(4'(o), 4'(n))});
      end
    end

    // R5 R8 loopback sweep
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        wr_ctl(8'h10 | 8'(o));
        rd_stat();
        wr_ctl(8'h10 | 8'(n));
        chk("R5 R8 loop status", stat_rdata,
            {loop_lines(4'(n)), exp_flags(loop_lines(4'(o)), loop_lines(4'(n)))});
      end
    end

    // R8 external changes ignored in loopback
    wr_ctl(8'h15);
    rd_stat();
    set_ext(4'hF);
    set_ext(4'h0);
    set_ext(4'hA);
    chk("R8 ext ignored", stat_rdata, {loop_lines(4'h5), 4'h0});
    chk("R8 irq quiet", {7'b0, irq}, 8'h00);

    // R9 set on same edge as read stays set
    wr_ctl(8'h10);
    rd_stat();
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h11; stat_rd = 1'b1;
    @(negedge clk); ctl_wr = 1'b0; stat_rd = 1'b0;
    chk("R9 set wins", {4'h0, stat_rdata[3:0]}, 8'h02);
    rd_stat();
    chk("R9 clear", {4'h0, stat_rdata[3:0]}, 8'h00);

    // leaving loopback raises nothing while ext held
    wr_ctl(8'h00);
    repeat (3) @(negedge clk);
    chk("R6 no flag on exit", {4'h0, stat_rdata[3:0]}, 8'h00);
    chk("R4 ext visible", {4'h0, stat_rdata[7:4]}, 8'h0A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule